// File: doc/BRIEF.md
# Indirect CSR Select Window

This block gives indirect read and write access to an array of backing registers through a select register and six alias registers. There is one such set for each of three privilege levels: machine, supervisor and virtual supervisor. Software first writes an index into a level's select register. It then reads or writes the aliases, which reach the backing entries chosen by that index. As a result, a large register array uses only eight CSR numbers per level, and software can reach any entry by index without a case per register.

The CSR port is single-cycle. A read returns data combinationally in the cycle it is requested. A write takes effect at the next rising clock edge. A per-access mode input selects 32-bit operation. In that mode each 64-bit backing entry is split: aliases 1 to 3 reach the low half and aliases 4 to 6 reach the high half. A virtualization flag steers the supervisor numbers to the virtual-supervisor state.

The block does not check privilege or state-enable permissions, and it does not deliver traps. It only reports that an access was illegal.

Top module: `icsr_window`

## Requirements
- R1: After reset, every select register and every backing entry reads zero.
- R2: Each level's window sits at a base address: 0x350 for machine, 0x150 for supervisor and 0x250 for virtual supervisor. The select register is at offset 0. Aliases 1, 2 and 3 are at offsets 1, 2 and 3. Aliases 4, 5 and 6 are at offsets 5, 6 and 7. Offset 4, and any address outside these windows, reads zero, changes no state and never raises `csr_illegal_o`.
- R3: A select write keeps only data bits [11:0] and the top bit. The top bit is bit 63 in 64-bit mode and bit 31 in 32-bit mode. On a read, all other bits are zero, and the stored top bit appears at the top position of the mode current at the time of the read.
- R4: An alias access (read or write) raises `csr_illegal_o` in the same cycle when the select holds an unimplemented value. A value is unimplemented when its top bit is set or its low field is 16 or more. The access then returns zero read data and its write is dropped.
- R5: In 64-bit mode, alias k (k = 1 to 3) reads and writes the whole 64-bit entry k-1 of the selected index. Aliases 4 to 6 read zero and ignore writes.
- R6: In 32-bit mode, alias k (k = 1 to 3) reaches bits [31:0] of entry k-1, and alias k+3 reaches bits [63:32] of the same entry. The data uses bits [31:0] of the port, and read bits [63:32] are zero.
- R7: For an implemented select value s, entry j is backed only when j <= s mod 4. An access to an unbacked entry reads zero, ignores the write and is not illegal.
- R8: While `virt_i` is 1, the addresses 0x150 to 0x157 reach the virtual-supervisor select register and backing array instead of the supervisor ones.
- R9: The machine, supervisor and virtual-supervisor levels each have their own select register and backing array. Writing one level never changes another.
- R10: A read and a write to the same register in the same cycle return the old value. The new value is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR number of the access |
| csr_re_i | input | 1 | Read enable |
| csr_we_i | input | 1 | Write enable |
| csr_wdata_i | input | 64 | Write data |
| virt_i | input | 1 | Hart runs in a virtual machine |
| xlen32_i | input | 1 | Current access uses 32-bit width |
| csr_rdata_o | output | 64 | Read data, zero when no read is requested |
| csr_illegal_o | output | 1 | Alias access with an unimplemented select value |

## Verification
A read and a write can land in the same cycle on one register, either the select register or an alias. In that case the combinational read path must show the pre-edge value while the write commits at the edge. The bench issues combined read-write operations on selects and aliases, both in directed steps and in a random phase. It compares read data in the access cycle against a behavioural model that applies the write only after comparing, and the following read confirms that the write landed. A select write followed at once by an alias access also exercises the case where the index changes between consecutive cycles.

// File: rtl/icsr_pkg.sv
package icsr_pkg;

  localparam int unsigned NUM_LVL = 3;

  typedef enum logic [1:0] {
    LVL_M  = 2'd0,
    LVL_S  = 2'd1,
    LVL_VS = 2'd2
  } icsr_lvl_e;

  typedef struct packed {
    logic      hit;
    logic      is_sel;
    icsr_lvl_e lvl;
    logic [2:0] alias_n;
  } icsr_dec_t;

  // entry j of index s is backed when j <= s mod 4
  function automatic logic slot_backed(input logic [1:0] sel_low, input logic [1:0] slot);
    return slot <= sel_low;
  endfunction

endpackage

// File: rtl/icsr_decode.sv
module icsr_decode
  import icsr_pkg::*;
(
  input  logic [11:0] addr_i,
  input  logic        virt_i,
  output icsr_dec_t   dec_o
);

  logic [2:0] off;
  logic       in_grp;

  always_comb begin
    off    = addr_i[2:0];
    in_grp = (addr_i[7:4] == 4'h5) && !addr_i[3] && (off != 3'd4);
    dec_o  = '0;
    case (addr_i[11:8])
      4'h3: begin dec_o.hit = in_grp; dec_o.lvl = LVL_M; end
      4'h1: begin dec_o.hit = in_grp; dec_o.lvl = virt_i ? LVL_VS : LVL_S; end
      4'h2: begin dec_o.hit = in_grp; dec_o.lvl = LVL_VS; end
      default: begin dec_o.hit = 1'b0; dec_o.lvl = LVL_M; end
    endcase
    dec_o.is_sel  = (off == 3'd0);
    // offsets 5..7 are aliases 4..6
    dec_o.alias_n = (off > 3'd4) ? off - 3'd1 : off;
  end

endmodule

// File: rtl/icsr_select.sv
module icsr_select #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned SEL_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                xlen32_i,
  input  logic [SEL_BITS-1:0] lo_i,
  input  logic                msb_i,
  output logic [SEL_BITS-1:0] sel_o,
  output logic                msb_o,
  output logic [XLEN-1:0]     rdata_o
);

  localparam int unsigned HALF = XLEN / 2;

  logic [SEL_BITS-1:0] sel_q;
  logic                msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      msb_q <= 1'b0;
    end else if (we_i) begin
      sel_q <= lo_i;
      msb_q <= msb_i;
    end
  end

  always_comb begin
    rdata_o                 = '0;
    rdata_o[SEL_BITS-1:0]   = sel_q;
    if (xlen32_i) rdata_o[HALF-1] = msb_q;
    else          rdata_o[XLEN-1] = msb_q;
  end

  assign sel_o = sel_q;
  assign msb_o = msb_q;

  assert_sel_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (sel_o == $past(lo_i)) && (msb_o == $past(msb_i)));

endmodule

// File: rtl/icsr_bank.sv
module icsr_bank #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NUM_SEL  = 16,
  parameter int unsigned NUM_SLOT = 3,
  parameter int unsigned IDX_W    = $clog2(NUM_SEL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       slot_i,
  input  logic             wr_en_i,
  input  logic [XLEN-1:0]  wr_mask_i,
  input  logic [XLEN-1:0]  wr_val_i,
  output logic [XLEN-1:0]  entry_o
);

  logic [XLEN-1:0] mem_q [NUM_SEL][NUM_SLOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SEL; i++)
        for (int j = 0; j < NUM_SLOT; j++)
          mem_q[i][j] <= '0;
    end else if (wr_en_i && (32'(slot_i) < NUM_SLOT)) begin
      mem_q[idx_i][slot_i] <= (mem_q[idx_i][slot_i] & ~wr_mask_i) | (wr_val_i & wr_mask_i);
    end
  end

  assign entry_o = (32'(slot_i) < NUM_SLOT) ? mem_q[idx_i][slot_i] : '0;

  assert_wr_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (32'(slot_i) < NUM_SLOT) && (wr_mask_i != '0));

endmodule

// File: rtl/icsr_window.sv
module icsr_window
  import icsr_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned SEL_BITS = 12,
  parameter int unsigned NUM_IMPL = 16,
  parameter int unsigned NUM_SLOT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_re_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            virt_i,
  input  logic            xlen32_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o
);

  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned IDX_W = $clog2(NUM_IMPL);

  icsr_dec_t dec;

  logic [SEL_BITS-1:0] sel_v   [NUM_LVL];
  logic                msb_v   [NUM_LVL];
  logic [XLEN-1:0]     sel_rd  [NUM_LVL];
  logic [XLEN-1:0]     entry_v [NUM_LVL];

  logic [SEL_BITS-1:0] cur_sel;
  logic                cur_msb;
  logic [XLEN-1:0]     cur_entry;
  logic                impl, hi_bank, backed, alias_acc, bank_we, wr_msb;
  logic [1:0]          slot;
  logic [XLEN-1:0]     alias_rd, wr_mask, wr_val;

  icsr_decode u_dec (
    .addr_i (csr_addr_i),
    .virt_i (virt_i),
    .dec_o  (dec)
  );

  assign wr_msb = xlen32_i ? csr_wdata_i[HALF-1] : csr_wdata_i[XLEN-1];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic lvl_hit;
    assign lvl_hit = dec.hit && (dec.lvl == icsr_lvl_e'(g));

    icsr_select #(.XLEN(XLEN), .SEL_BITS(SEL_BITS)) u_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (csr_we_i && lvl_hit && dec.is_sel),
      .xlen32_i (xlen32_i),
      .lo_i     (csr_wdata_i[SEL_BITS-1:0]),
      .msb_i    (wr_msb),
      .sel_o    (sel_v[g]),
      .msb_o    (msb_v[g]),
      .rdata_o  (sel_rd[g])
    );

    icsr_bank #(.XLEN(XLEN), .NUM_SEL(NUM_IMPL), .NUM_SLOT(NUM_SLOT), .IDX_W(IDX_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .idx_i     (sel_v[g][IDX_W-1:0]),
      .slot_i    (slot),
      .wr_en_i   (bank_we && lvl_hit),
      .wr_mask_i (wr_mask),
      .wr_val_i  (wr_val),
      .entry_o   (entry_v[g])
    );
  end

  always_comb begin
    cur_sel   = sel_v[dec.lvl];
    cur_msb   = msb_v[dec.lvl];
    cur_entry = entry_v[dec.lvl];
    impl      = !cur_msb && (32'(cur_sel) < NUM_IMPL);
    hi_bank   = dec.alias_n >= 3'd4;
    slot      = hi_bank ? 2'(dec.alias_n - 3'd4) : 2'(dec.alias_n - 3'd1);
    backed    = slot_backed(cur_sel[1:0], slot);
    alias_acc = dec.hit && !dec.is_sel;
  end

  always_comb begin
    alias_rd = '0;
    if (impl && backed) begin
      if (!xlen32_i)    alias_rd = hi_bank ? '0 : cur_entry;
      else if (hi_bank) alias_rd[HALF-1:0] = cur_entry[XLEN-1:HALF];
      else              alias_rd[HALF-1:0] = cur_entry[HALF-1:0];
    end
  end

  always_comb begin
    wr_mask = '0;
    wr_val  = '0;
    if (!xlen32_i) begin
      wr_mask = '1;
      wr_val  = csr_wdata_i;
    end else if (hi_bank) begin
      wr_mask[XLEN-1:HALF] = '1;
      wr_val[XLEN-1:HALF]  = csr_wdata_i[HALF-1:0];
    end else begin
      wr_mask[HALF-1:0] = '1;
      wr_val[HALF-1:0]  = csr_wdata_i[HALF-1:0];
    end
  end

  assign bank_we       = csr_we_i && alias_acc && impl && backed && (xlen32_i || !hi_bank);
  assign csr_illegal_o = alias_acc && (csr_re_i || csr_we_i) && !impl;

  always_comb begin
    csr_rdata_o = '0;
    if (csr_re_i && dec.hit)
      csr_rdata_o = dec.is_sel ? sel_rd[dec.lvl] : alias_rd;
  end

  assert_illegal_access_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> (csr_re_i || csr_we_i));

  assert_illegal_rdata_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> (csr_rdata_o == '0));

  assert_narrow_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlen32_i && csr_re_i) |-> (csr_rdata_o[XLEN-1:HALF] == '0));

  assert_gap_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i[3:0] == 4'h4) |-> (!csr_illegal_o && (csr_rdata_o == '0)));

  assert_wide_hibank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xlen32_i && csr_re_i && dec.hit && !dec.is_sel && hi_bank) |-> (csr_rdata_o == '0));

endmodule

// File: tb/tb_icsr_window.sv
module tb_icsr_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        re = 1'b0, we = 1'b0, virt = 1'b0, x32 = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        illegal;

  always #5 clk = ~clk;

  icsr_window dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .csr_addr_i    (addr),
    .csr_re_i      (re),
    .csr_we_i      (we),
    .csr_wdata_i   (wdata),
    .virt_i        (virt),
    .xlen32_i      (x32),
    .csr_rdata_o   (rdata),
    .csr_illegal_o (illegal)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [11:0] m_sel [3];
  bit          m_msb [3];
  logic [63:0] m_mem [3][16][3];

  task automatic op(input logic [11:0] a_in, input bit r, input bit w, input logic [63:0] wd,
                    input bit v, input bit n32, input string tag_in);
    int lvl, off, a, slot;
    bit valid, impl, backed, hi;
    logic [63:0] exp_rd;
    bit exp_il;
    string tag;
    lvl = -1;
    case (a_in[11:8])
      4'h3: lvl = 0;
      4'h1: lvl = v ? 2 : 1;
      4'h2: lvl = 2;
      default: lvl = -1;
    endcase
    off = int'(a_in[3:0]);
    valid = (lvl >= 0) && (a_in[7:4] == 4'h5) && (off < 8) && (off != 4);
    exp_rd = '0; exp_il = 0; impl = 0; backed = 0; hi = 0; slot = 0;
    if (valid && off == 0) begin
      if (r) begin
        exp_rd = 64'(m_sel[lvl]);
        if (n32) exp_rd[31] = m_msb[lvl]; else exp_rd[63] = m_msb[lvl];
      end
    end else if (valid) begin
      a = (off < 4) ? off : off - 1;
      impl = !m_msb[lvl] && (m_sel[lvl] < 16);
      if (!impl) exp_il = r || w;
      else begin
        hi = a >= 4;
        slot = hi ? a - 4 : a - 1;
        backed = slot <= int'(m_sel[lvl] % 4);
        if (r && backed) begin
          if (!n32) exp_rd = hi ? 64'd0 : m_mem[lvl][m_sel[lvl]][slot];
          else if (hi) exp_rd = {32'd0, m_mem[lvl][m_sel[lvl]][slot][63:32]};
          else exp_rd = {32'd0, m_mem[lvl][m_sel[lvl]][slot][31:0]};
        end
      end
    end
    tag = tag_in;
    if (tag == "") begin
      if (!valid) tag = "R2";
      else if (off == 0) tag = "R3";
      else if (exp_il) tag = "R4";
      else if (n32) tag = "R6";
      else tag = "R5";
    end
    @(negedge clk);
    addr = a_in; re = r; we = w; wdata = wd; virt = v; x32 = n32;
    #1;
    n_vec++;
    if (rdata !== exp_rd || illegal !== exp_il) begin
      n_bad++;
      $display("FAIL %s addr=%h rdata=%h exp=%h illegal=%0b exp=%0b", tag, a_in, rdata, exp_rd, illegal, exp_il);
    end
    if (w && valid) begin
      if (off == 0) begin
        m_sel[lvl] = wd[11:0];
        m_msb[lvl] = n32 ? wd[31] : wd[63];
      end else if (impl && backed) begin
        if (!n32 && !hi) m_mem[lvl][m_sel[lvl]][slot] = wd;
        else if (n32 && !hi) m_mem[lvl][m_sel[lvl]][slot][31:0] = wd[31:0];
        else if (n32 && hi) m_mem[lvl][m_sel[lvl]][slot][63:32] = wd[31:0];
      end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 3; l++) begin
      m_sel[l] = '0; m_msb[l] = 0;
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 3; j++) m_mem[l][i][j] = '0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    op(12'h350, 1, 0, 0, 0, 0, "R1");
    op(12'h150, 1, 0, 0, 0, 0, "R1");
    op(12'h250, 1, 0, 0, 0, 0, "R1");
    op(12'h351, 1, 0, 0, 0, 0, "R1");
    // R3 select WARL and top-bit position
    op(12'h350, 0, 1, 64'hFFFF_FFFF_FFFF_F005, 0, 0, "R3");
    op(12'h350, 1, 0, 0, 0, 0, "R3");
    op(12'h350, 1, 0, 0, 0, 1, "R3");
    // R4 custom select value
    op(12'h351, 1, 0, 0, 0, 0, "R4");
    op(12'h351, 0, 1, 64'h1111, 0, 0, "R4");
    // R5 full-width aliases
    op(12'h350, 0, 1, 64'h3, 0, 0, "R5");
    op(12'h351, 0, 1, 64'hA0A0_0001_1234_5678, 0, 0, "R5");
    op(12'h352, 0, 1, 64'hB0B0_0002_0000_0002, 0, 0, "R5");
    op(12'h353, 0, 1, 64'hC0C0_0003_0000_0003, 0, 0, "R5");
    op(12'h351, 1, 0, 0, 0, 0, "R5");
    op(12'h353, 1, 0, 0, 0, 0, "R5");
    op(12'h355, 1, 1, 64'hDEAD, 0, 0, "R5");
    op(12'h355, 1, 0, 0, 0, 0, "R5");
    // R2 gap and foreign address
    op(12'h354, 1, 1, 64'hFFFF, 0, 0, "R2");
    op(12'h358, 1, 1, 64'hFFFF, 0, 0, "R2");
    op(12'h340, 1, 1, 64'hFFFF, 0, 0, "R2");
    // R6 narrow halves
    op(12'h351, 1, 0, 0, 0, 1, "R6");
    op(12'h355, 1, 0, 0, 0, 1, "R6");
    op(12'h355, 0, 1, 64'hFFFF_FFFF_8765_4321, 0, 1, "R6");
    op(12'h352, 0, 1, 64'h0000_0000_5555_AAAA, 0, 1, "R6");
    op(12'h351, 1, 0, 0, 0, 0, "R6");
    op(12'h352, 1, 0, 0, 0, 0, "R6");
    // R4 index out of range
    op(12'h350, 0, 1, 64'h10, 0, 0, "R4");
    op(12'h352, 1, 0, 0, 0, 0, "R4");
    // R7 unbacked slot
    op(12'h350, 0, 1, 64'h1, 0, 0, "R7");
    op(12'h353, 0, 1, 64'h9999, 0, 0, "R7");
    op(12'h353, 1, 0, 0, 0, 0, "R7");
    op(12'h352, 1, 0, 0, 0, 0, "R7");
    op(12'h350, 0, 1, 64'h3, 0, 0, "R7");
    op(12'h353, 1, 0, 0, 0, 0, "R7");
    // R9 level separation
    op(12'h150, 0, 1, 64'h3, 0, 0, "R9");
    op(12'h151, 0, 1, 64'h5151, 0, 0, "R9");
    op(12'h351, 1, 0, 0, 0, 0, "R9");
    op(12'h151, 1, 0, 0, 0, 0, "R9");
    op(12'h251, 1, 0, 0, 0, 0, "R9");
    // R8 redirect under virtualization
    op(12'h150, 0, 1, 64'h2, 1, 0, "R8");
    op(12'h250, 1, 0, 0, 0, 0, "R8");
    op(12'h150, 1, 0, 0, 0, 0, "R8");
    op(12'h152, 0, 1, 64'h7272, 1, 0, "R8");
    op(12'h252, 1, 0, 0, 0, 0, "R8");
    op(12'h152, 1, 0, 0, 0, 0, "R8");
    // R10 read and write in one cycle
    op(12'h351, 1, 1, 64'h0F0F_0F0F, 0, 0, "R10");
    op(12'h351, 1, 0, 0, 0, 0, "R10");
    op(12'h350, 1, 1, 64'h2, 0, 0, "R10");
    op(12'h350, 1, 0, 0, 0, 0, "R10");

    for (int k = 0; k < 3000; k++) begin
      logic [11:0] ra;
      logic [63:0] rw;
      int o;
      o = int'($urandom % 9);
      case ($urandom % 3)
        0: ra = 12'h350;
        1: ra = 12'h150;
        default: ra = 12'h250;
      endcase
      ra = ra + 12'(o);
      if ($urandom % 16 == 0) ra = 12'h300;
      rw = {$urandom, $urandom};
      if (o == 0 && ($urandom % 4 != 0)) rw = 64'($urandom % 20);
      op(ra, bit'($urandom % 2), bit'($urandom % 2), rw,
         bit'($urandom % 4 == 0), bit'($urandom % 3 == 0), "");
    end

    @(negedge clk);
    re = 0; we = 0;
    done = 1;
    summary();
    $finish;
  end

endmodule